// File: doc/BRIEF.md
# Dual-Port Word Memory with Selectable Write Masking

A synchronous memory of 4096 words, each 72 bits wide, reached through two ports, A and B, that share one clock. In any cycle each port can read or write any word, with no dependence on what the other port is doing. Every word holds eight data lanes of eight bits in bits 63:0, where lane i occupies bits 8i+7:8i. Bits 71:64 hold eight parity bits, and bit 64+i belongs to lane i. The memory stores the parity bits as supplied and does not compute them.

A parameter fixes how the per-lane enables shape a write. In byte mode, the 8-bit data enable of a port covers both a lane and that lane's parity bit, and the port's parity enable input is ignored. In split mode, the data enable covers only the lane bits, and a separate 8-bit parity enable covers only the parity bits.

Each port is a plain request interface: `en` together with `we` requests a write, and `en` with `we` low requests a read. Every request is accepted in the cycle it is presented. There is no back-pressure, and no valid/ready pair is needed. Read data is registered. A port whose `en` is high also reads the old contents of its address in a write cycle (read-before-write).

Top module: `dpram_2wm`

## Requirements
- R1: While `rst_n` is low at a rising edge, both `a_rdata` and `b_rdata` become all zero, whatever the port inputs are.
- R2: A port with `en` high at a rising edge presents the word stored at its address on its `rdata` immediately after that edge, which is one cycle of read latency.
- R3: In byte mode, `dwe[i]` set on a write updates bits 8i+7:8i and parity bit 64+i from `wdata`. All other bits keep their values, and `pwe` has no effect.
- R4: In split mode, `dwe[i]` updates only bits 8i+7:8i, and `pwe[i]` updates only parity bit 64+i. Each enable acts regardless of the other.
- R5: A port with `en` low writes nothing, whatever `we` is, and its `rdata` keeps its previous value.
- R6: Both ports may read and/or write different addresses in the same cycle, and each sees only its own result.
- R7: When both ports write the same address in the same cycle, every bit enabled on port A takes A's data. Bits enabled only on port B take B's data, and bits enabled on neither port keep their values.
- R8: A read of an address that either port writes in the same cycle returns the contents from before that write.
- R9: Both ports reach every address, including 0 and 4095.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset of the read registers |
| a_en | input | 1 | Port A request enable |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | 12 | Port A word address |
| a_wdata | input | 72 | Port A write data, lanes then parity |
| a_dwe | input | 8 | Port A per-lane data enables |
| a_pwe | input | 8 | Port A per-lane parity enables (split mode only) |
| a_rdata | output | 72 | Port A registered read data |
| b_en | input | 1 | Port B request enable |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | 12 | Port B word address |
| b_wdata | input | 72 | Port B write data, lanes then parity |
| b_dwe | input | 8 | Port B per-lane data enables |
| b_pwe | input | 8 | Port B per-lane parity enables (split mode only) |
| b_rdata | output | 72 | Port B registered read data |

## Verification
A wrong stored bit stays hidden until that address is read again. It then shows on the read port exactly one cycle after the read request, so every write the bench makes is followed by reads of the same small address pool. A wrong enable mapping or a wrong collision merge corrupts only the masked lanes or parity bits. For that reason, both mode variants run under identical stimulus, and partial masks are compared bit for bit. A read register that fails to hold or fails to clear shows at the very next edge.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic {
    WEN_BYTE  = 1'b0,
    WEN_SPLIT = 1'b1
  } wen_mode_e;
endpackage

// File: rtl/dpr_wen_map.sv
module dpr_wen_map
  import dpr_pkg::*;
#(
  parameter wen_mode_e MODE   = WEN_BYTE,
  parameter int        LANES  = 8,
  parameter int        LANE_W = 8,
  localparam int       WORD_W = LANES * (LANE_W + 1)
) (
  input  logic              wr,
  input  logic [LANES-1:0]  dwe,
  input  logic [LANES-1:0]  pwe,
  output logic [WORD_W-1:0] mask
);
  localparam int PAR_LSB = LANES * LANE_W;

  logic [LANES-1:0] par_sel;

  generate
    if (MODE == WEN_SPLIT) begin : g_split
      assign par_sel = pwe;
    end else begin : g_byte
      logic unused_pwe;
      assign par_sel    = dwe;
      assign unused_pwe = ^pwe;
    end
  endgenerate

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask[i*LANE_W +: LANE_W] = {LANE_W{wr & dwe[i]}};
    assign mask[PAR_LSB + i]        = wr & par_sel[i];
  end
endmodule

// File: rtl/dpr_collide.sv
module dpr_collide #(
  parameter int AW = 12,
  parameter int W  = 72
) (
  input  logic          a_wr,
  input  logic          b_wr,
  input  logic [AW-1:0] a_addr,
  input  logic [AW-1:0] b_addr,
  input  logic [W-1:0]  a_mask,
  input  logic [W-1:0]  a_data,
  input  logic [W-1:0]  b_mask,
  input  logic [W-1:0]  b_data,
  output logic          a_go,
  output logic          b_go,
  output logic [W-1:0]  a_mask_eff,
  output logic [W-1:0]  a_data_eff
);
  logic same;

  assign same       = a_wr & b_wr & (a_addr == b_addr);
  assign a_go       = a_wr;
  assign b_go       = b_wr & ~same;
  assign a_mask_eff = same ? (a_mask | b_mask) : a_mask;
  assign a_data_eff = same ? ((a_data & a_mask) | (b_data & b_mask & ~a_mask)) : a_data;
endmodule

// File: rtl/dpr_array.sv
module dpr_array #(
  parameter int  AW    = 12,
  parameter int  W     = 72,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_rd,
  input  logic [AW-1:0] a_addr,
  input  logic          a_go,
  input  logic [W-1:0]  a_mask,
  input  logic [W-1:0]  a_data,
  output logic [W-1:0]  a_rdata,
  input  logic          b_rd,
  input  logic [AW-1:0] b_addr,
  input  logic          b_go,
  input  logic [W-1:0]  b_mask,
  input  logic [W-1:0]  b_data,
  output logic [W-1:0]  b_rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (b_go) mem[b_addr] <= (mem[b_addr] & ~b_mask) | (b_data & b_mask);
    if (a_go) mem[a_addr] <= (mem[a_addr] & ~a_mask) | (a_data & a_mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_rd) a_rdata <= mem[a_addr];
      if (b_rd) b_rdata <= mem[b_addr];
    end
  end

  p_rst_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (a_rdata == '0 && b_rdata == '0));

  p_hold_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !a_rd |=> $stable(a_rdata));

  p_hold_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !b_rd |=> $stable(b_rdata));
endmodule

// File: rtl/dpram_2wm.sv
module dpram_2wm
  import dpr_pkg::*;
#(
  parameter wen_mode_e MODE   = WEN_BYTE,
  parameter int        AW     = 12,
  parameter int        LANES  = 8,
  parameter int        LANE_W = 8,
  localparam int       W      = LANES * (LANE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [AW-1:0]     a_addr,
  input  logic [W-1:0]      a_wdata,
  input  logic [LANES-1:0]  a_dwe,
  input  logic [LANES-1:0]  a_pwe,
  output logic [W-1:0]      a_rdata,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [AW-1:0]     b_addr,
  input  logic [W-1:0]      b_wdata,
  input  logic [LANES-1:0]  b_dwe,
  input  logic [LANES-1:0]  b_pwe,
  output logic [W-1:0]      b_rdata
);
  logic         a_wr, b_wr, a_go, b_go;
  logic [W-1:0] a_mask, b_mask, a_mask_eff, a_data_eff;

  assign a_wr = a_en & a_we;
  assign b_wr = b_en & b_we;

  dpr_wen_map #(.MODE(MODE), .LANES(LANES), .LANE_W(LANE_W)) u_map_a (
    .wr(a_wr), .dwe(a_dwe), .pwe(a_pwe), .mask(a_mask)
  );

  dpr_wen_map #(.MODE(MODE), .LANES(LANES), .LANE_W(LANE_W)) u_map_b (
    .wr(b_wr), .dwe(b_dwe), .pwe(b_pwe), .mask(b_mask)
  );

  dpr_collide #(.AW(AW), .W(W)) u_coll (
    .a_wr(a_wr), .b_wr(b_wr), .a_addr(a_addr), .b_addr(b_addr),
    .a_mask(a_mask), .a_data(a_wdata), .b_mask(b_mask), .b_data(b_wdata),
    .a_go(a_go), .b_go(b_go), .a_mask_eff(a_mask_eff), .a_data_eff(a_data_eff)
  );

  dpr_array #(.AW(AW), .W(W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .a_rd(a_en), .a_addr(a_addr), .a_go(a_go), .a_mask(a_mask_eff),
    .a_data(a_data_eff), .a_rdata(a_rdata),
    .b_rd(b_en), .b_addr(b_addr), .b_go(b_go), .b_mask(b_mask),
    .b_data(b_wdata), .b_rdata(b_rdata)
  );

  // Full-mask write on A, then a read of the same address, returns that data.
  p_wr_then_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr && a_mask == '1) ##1 (a_en && !a_we && a_addr == $past(a_addr))
    |=> (a_rdata == $past(a_wdata, 2)));

  // On a same-address collision, A-enabled bits read back as A's data.
  p_a_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr && b_wr && a_addr == b_addr) ##1 (a_en && !a_we && a_addr == $past(a_addr))
    |=> ((a_rdata & $past(a_mask, 2)) == ($past(a_wdata, 2) & $past(a_mask, 2))));
endmodule

// File: tb/tb_dpram_2wm.sv
`timescale 1ns/1ps
module tb_dpram_2wm;
  localparam int AW = 12, LN = 8, W = 72, DEPTH = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          a_en, a_we, b_en, b_we;
  logic [AW-1:0] a_addr, b_addr;
  logic [W-1:0]  a_wdata, b_wdata;
  logic [LN-1:0] a_dwe, a_pwe, b_dwe, b_pwe;
  logic [W-1:0]  ya_b, yb_b, ya_s, yb_s;

  dpram_2wm #(.MODE(dpr_pkg::WEN_BYTE)) dut (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_dwe(a_dwe), .a_pwe(a_pwe), .a_rdata(ya_b),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_dwe(b_dwe), .b_pwe(b_pwe), .b_rdata(yb_b)
  );

  dpram_2wm #(.MODE(dpr_pkg::WEN_SPLIT)) dut_split (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_dwe(a_dwe), .a_pwe(a_pwe), .a_rdata(ya_s),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_dwe(b_dwe), .b_pwe(b_pwe), .b_rdata(yb_s)
  );

  logic [W-1:0] mdl_b [DEPTH];
  logic [W-1:0] mdl_s [DEPTH];
  logic [W-1:0] e_ab, e_bb, e_as, e_bs;
  int  checks = 0, errors = 0;
  bit  done = 1'b0;

  function automatic logic [W-1:0] mask_of(bit split, logic [LN-1:0] dwe, logic [LN-1:0] pwe);
    logic [W-1:0] m = '0;
    for (int i = 0; i < LN; i++) begin
      m[8*i +: 8] = {8{dwe[i]}};
      m[64 + i]   = split ? pwe[i] : dwe[i];
    end
    return m;
  endfunction

  function automatic logic [W-1:0] merge(logic [W-1:0] old, logic [W-1:0] d, logic [W-1:0] m);
    return (old & ~m) | (d & m);
  endfunction

  function automatic logic [W-1:0] rnd_word();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  function automatic logic [AW-1:0] pick_addr();
    int k = $urandom_range(0, 17);
    if (k < 16) return AW'(k);
    return (k == 16) ? 12'd4095 : 12'd4094;
  endfunction

  task automatic check(string tag, string nm, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, nm, act, exp);
    end
  endtask

  task automatic idle();
    a_en = 0; a_we = 0; a_addr = '0; a_wdata = '0; a_dwe = '0; a_pwe = '0;
    b_en = 0; b_we = 0; b_addr = '0; b_wdata = '0; b_dwe = '0; b_pwe = '0;
  endtask

  // Called at a falling edge with inputs applied; checks after the next rising edge.
  task automatic step(string tag);
    if (a_en) begin e_ab = mdl_b[a_addr]; e_as = mdl_s[a_addr]; end
    if (b_en) begin e_bb = mdl_b[b_addr]; e_bs = mdl_s[b_addr]; end
    if (b_en && b_we) begin
      mdl_b[b_addr] = merge(mdl_b[b_addr], b_wdata, mask_of(0, b_dwe, b_pwe));
      mdl_s[b_addr] = merge(mdl_s[b_addr], b_wdata, mask_of(1, b_dwe, b_pwe));
    end
    if (a_en && a_we) begin
      mdl_b[a_addr] = merge(mdl_b[a_addr], a_wdata, mask_of(0, a_dwe, a_pwe));
      mdl_s[a_addr] = merge(mdl_s[a_addr], a_wdata, mask_of(1, a_dwe, a_pwe));
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "byte.a", ya_b, e_ab);
    check(tag, "byte.b", yb_b, e_bb);
    check(tag, "split.a", ya_s, e_as);
    check(tag, "split.b", yb_s, e_bs);
  endtask

  task automatic wr(bit port_a, logic [AW-1:0] ad, logic [W-1:0] d, logic [LN-1:0] dw, logic [LN-1:0] pw);
    if (port_a) begin a_en = 1; a_we = 1; a_addr = ad; a_wdata = d; a_dwe = dw; a_pwe = pw; end
    else begin b_en = 1; b_we = 1; b_addr = ad; b_wdata = d; b_dwe = dw; b_pwe = pw; end
  endtask

  task automatic rd(bit port_a, logic [AW-1:0] ad);
    if (port_a) begin a_en = 1; a_we = 0; a_addr = ad; end
    else begin b_en = 1; b_we = 0; b_addr = ad; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    idle();
    e_ab = '0; e_bb = '0; e_as = '0; e_bs = '0;
    // R1: reset clears read registers even with reads requested
    @(negedge clk);
    a_en = 1; b_en = 1; a_addr = 12'd1; b_addr = 12'd2;
    repeat (2) begin
      @(posedge clk); @(negedge clk);
      check("R1", "byte.a", ya_b, '0);
      check("R1", "byte.b", yb_b, '0);
      check("R1", "split.a", ya_s, '0);
      check("R1", "split.b", yb_s, '0);
    end
    idle();
    rst_n = 1'b1;
    step("R5");

    // R9: fill the address pool with full-mask writes, both ports, extremes included
    for (int k = 0; k < 18; k += 2) begin
      idle();
      wr(1, (k < 16) ? AW'(k) : 12'd4095, rnd_word(), 8'hFF, 8'hFF);
      wr(0, (k < 16) ? AW'(k + 1) : 12'd4094, rnd_word(), 8'hFF, 8'hFF);
      step("R9");
    end
    idle(); rd(1, 12'd4095); rd(0, 12'd0); step("R9");
    idle(); rd(1, 12'd1); rd(0, 12'd4094); step("R9");

    // R2: write then read on the next cycle
    idle(); wr(1, 12'd5, rnd_word(), 8'hFF, 8'hFF); step("R2");
    idle(); rd(1, 12'd5); step("R2");

    // R3 (byte dut) / R4 (split dut): partial lane and parity enables
    idle(); wr(1, 12'd3, rnd_word(), 8'b0000_0101, 8'b1010_0000); step("R3");
    idle(); rd(1, 12'd3); rd(0, 12'd3); step("R4");
    idle(); wr(0, 12'd4, rnd_word(), 8'h00, 8'hFF); step("R4");
    idle(); rd(0, 12'd4); step("R3");

    // R5: write request with en low has no effect; rdata holds
    idle(); a_we = 1; a_addr = 12'd3; a_wdata = rnd_word(); a_dwe = 8'hFF; a_pwe = 8'hFF; step("R5");
    idle(); rd(1, 12'd3); step("R5");

    // R6: independent writes then crossed reads
    idle(); wr(1, 12'd7, rnd_word(), 8'hF0, 8'h0F); wr(0, 12'd8, rnd_word(), 8'h3C, 8'hC3); step("R6");
    idle(); rd(1, 12'd8); rd(0, 12'd7); step("R6");

    // R7: same-address collision with overlapping masks
    idle(); wr(1, 12'd9, rnd_word(), 8'b0011_0011, 8'b0101_0101);
    wr(0, 12'd9, rnd_word(), 8'b0110_0110, 8'b1111_0000); step("R7");
    idle(); rd(1, 12'd9); rd(0, 12'd9); step("R7");

    // R8: read of an address written in the same cycle returns old data
    idle(); wr(1, 12'd10, rnd_word(), 8'hFF, 8'hFF); rd(0, 12'd10); step("R8");
    idle(); wr(0, 12'd11, rnd_word(), 8'hAA, 8'h55); rd(1, 12'd11); step("R8");
    idle(); rd(1, 12'd10); rd(0, 12'd11); step("R8");

    // R6: constrained random mix over the address pool
    for (int n = 0; n < 3000; n++) begin
      idle();
      a_en = ($urandom_range(0, 3) != 0); a_we = $urandom_range(0, 1);
      b_en = ($urandom_range(0, 3) != 0); b_we = $urandom_range(0, 1);
      a_addr = pick_addr(); b_addr = ($urandom_range(0, 3) == 0) ? a_addr : pick_addr();
      a_wdata = rnd_word(); b_wdata = rnd_word();
      a_dwe = LN'($urandom()); a_pwe = LN'($urandom());
      b_dwe = LN'($urandom()); b_pwe = LN'($urandom());
      step("R6");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule